// File: doc/BRIEF.md
# DDR SDRAM Command Bus Monitor

This block sits beside a DDR SDRAM command bus and watches it on each rising clock edge. It turns the chip select, the three strobes, the clock-enable pair, the bank bits and A10 into one decoded command. It tracks whether each of the four banks holds an open row, and whether the device is active, in self refresh or in one of the two power-down states. It is used in a controller or test harness to catch command sequences that the memory would not accept.

Every cycle the block publishes the decoded command, the bank it targets and the auto-precharge request. When the command breaks an issue rule, it raises a flag with a reason code. A flagged command changes neither the bank state nor the power state. The burst length and the quiet gap after a mode-register write are parameters.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: All outputs are registered. The values sampled at a rising edge appear on the outputs just after that edge. `cmd_o` codes are: NOP=0, mode set=1, extended mode set=2, auto refresh=3, self-refresh entry=4, self-refresh exit=5, activate=6, read=7, write=8, burst stop=9, precharge one bank=10, precharge all=11, power-down entry=12, power-down exit=13. With chip select low and CKE high in both cycles, {RAS,CAS,WE} 000 is a mode set: code 1 when the bank bits are 00, code 2 otherwise. The other strobe codes are 001 refresh, 011 activate, 101 read, 100 write, 110 burst stop and 010 precharge.
- R2: Strobe code 111, or any cycle with chip select high, decodes as NOP and opens or closes no bank.
- R3: Bank bits 00, 01, 10 and 11 (BA1,BA0) select banks 0, 1, 2 and 3, which appear on `bank_o` and as bits 0..3 of `bank_open_o`. An accepted activate sets that bank's bit.
- R4: `auto_pre_o` is 1 only for a read or write sampled with A10 high.
- R5: A precharge with A10 low closes only the addressed bank. With A10 high it reports code 11 and closes all banks, whatever the bank bits are.
- R6: A mode set (either kind) while any bank is open is flagged with reason 2. After an accepted mode set, any non-NOP command in the next MRS_GAP (default 2) cycles is flagged with reason 1.
- R7: An auto refresh or a self-refresh entry while any bank is open is flagged with reason 3.
- R8: Refresh code with CKE going high to low is a self-refresh entry, and `pwr_o` goes to 1. In self refresh, CKE rising from low to high gives code 5 and returns `pwr_o` to 0. A cycle with CKE low in both samples decodes as NOP.
- R9: CKE going high to low on a NOP or deselect cycle is power-down entry. `pwr_o` becomes 2 if any bank is open and 3 otherwise. CKE rising then gives code 13 and `pwr_o` 0.
- R10: An accepted read or write with auto precharge closes its bank BURST_LEN/2 cycles after the command edge. With the default of 4 beats, the bank shows closed after the second following edge.
- R11: After an accepted write with auto precharge, a read or write to any bank in the next BURST_LEN/2 cycles is flagged with reason 6.
- R12: An activate to an open bank is flagged with reason 4. A read or write to a closed bank is flagged with reason 5. CKE going high to low on any code other than refresh or NOP is flagged with reason 7. Priority is reason 1, then 7, then the command's own reason. Any flagged command leaves all state unchanged.
- R13: While reset is low, `cmd_o` is NOP, all banks are closed, `pwr_o` is 0 and no violation is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_prev_i | input | 1 | Clock enable as sampled in the previous cycle |
| cke_i | input | 1 | Clock enable in this cycle |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank bits {BA1,BA0} |
| a10_i | input | 1 | Address bit 10 (auto precharge / all banks) |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | 2 | Bank addressed by the command |
| auto_pre_o | output | 1 | Read or write requested auto precharge |
| bank_open_o | output | 4 | One bit per bank, 1 when a row is open |
| pwr_o | output | 2 | 0 active, 1 self refresh, 2 active power-down, 3 precharge power-down |
| viol_o | output | 1 | Command broke an issue rule |
| viol_code_o | output | 3 | Reason for the violation, 0 when none |

## Verification
The hardest situation to reach is a command that lands inside the burst window of a write with auto precharge. It must arrive on exactly the first or second edge after the write, while the target bank is still open and no mode-set gap is running. The bench opens two banks, issues the write with auto precharge to one, then places a read and a write to the other bank on the two following edges. A third access one edge later checks that the block is free again and that the written bank has closed by then. The mode-set gap is reached the same way: an activate right after the mode set, a NOP, then an activate on the edge where the gap has run out.

// File: rtl/ddrmon_pkg.sv
// Shared types for the DDR command bus monitor.
package ddrmon_pkg;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_MRS  = 4'd1,
        CMD_EMRS = 4'd2,
        CMD_REF  = 4'd3,
        CMD_SRE  = 4'd4,
        CMD_SRX  = 4'd5,
        CMD_ACT  = 4'd6,
        CMD_RD   = 4'd7,
        CMD_WR   = 4'd8,
        CMD_BST  = 4'd9,
        CMD_PRE  = 4'd10,
        CMD_PREA = 4'd11,
        CMD_PDE  = 4'd12,
        CMD_PDX  = 4'd13
    } cmd_e;

    typedef enum logic [1:0] {
        PWR_ACTIVE = 2'd0,
        PWR_SELF   = 2'd1,
        PWR_PD_ACT = 2'd2,
        PWR_PD_PRE = 2'd3
    } pwr_e;

    typedef enum logic [2:0] {
        V_NONE      = 3'd0,
        V_MRS_GAP   = 3'd1,
        V_MRS_OPEN  = 3'd2,
        V_REF_OPEN  = 3'd3,
        V_ACT_OPEN  = 3'd4,
        V_CLOSED    = 3'd5,
        V_WRAP_BUSY = 3'd6,
        V_CKE_BAD   = 3'd7
    } viol_e;

endpackage

// File: rtl/ddrmon_decode.sv
// Combinational command decoder.
// Turns chip select, the strobes and the CKE pair into one command.
// Assumes the caller supplies the current power state so that a CKE
// rising edge can be named as a self-refresh exit or a power-down exit.
module ddrmon_decode
    import ddrmon_pkg::*;
(
    input  logic       cke_prev,
    input  logic       cke,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic [1:0] ba,
    input  logic       a10,
    input  pwr_e       pwr,
    output cmd_e       cmd,
    output logic       cke_bad
);

    cmd_e base;

    // Strobe code to command, ignoring CKE
    always_comb begin
        if (cs_n) begin
            base = CMD_NOP;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b000:  base = (ba == 2'b00) ? CMD_MRS : CMD_EMRS;
                3'b001:  base = CMD_REF;
                3'b011:  base = CMD_ACT;
                3'b101:  base = CMD_RD;
                3'b100:  base = CMD_WR;
                3'b110:  base = CMD_BST;
                3'b010:  base = a10 ? CMD_PREA : CMD_PRE;
                default: base = CMD_NOP;
            endcase
        end
    end

    // CKE transitions turn the base command into power-state commands
    always_comb begin
        cmd     = base;
        cke_bad = 1'b0;
        case ({cke_prev, cke})
            2'b10: begin
                if (base == CMD_REF)      cmd = CMD_SRE;
                else if (base == CMD_NOP) cmd = CMD_PDE;
                else                      cke_bad = 1'b1;
            end
            2'b01: begin
                if (pwr == PWR_SELF)        cmd = CMD_SRX;
                else if (pwr != PWR_ACTIVE) cmd = CMD_PDX;
                else                        cmd = CMD_NOP;
            end
            2'b00:   cmd = CMD_NOP;
            default: cmd = base;
        endcase
    end

endmodule

// File: rtl/ddrmon_banks.sv
// Per-bank row state with an auto-precharge countdown.
// Assumes accept is low for any flagged command, so only legal
// commands move state. A bank with auto precharge closes when its
// countdown expires.
module ddrmon_banks
    import ddrmon_pkg::*;
#(
    parameter int NBANK     = 4,
    parameter int BURST_CYC = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     accept,
    input  cmd_e                     cmd,
    input  logic [$clog2(NBANK)-1:0] bank,
    input  logic                     ap,
    output logic [NBANK-1:0]         open,
    output logic                     wrap_busy
);

    localparam int CW = $clog2(BURST_CYC + 1);

    logic [NBANK-1:0] busy_vec;

    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        logic [CW-1:0] cnt;
        logic          is_wr;
        logic          sel;

        assign sel         = (bank == i[$clog2(NBANK)-1:0]);
        assign busy_vec[i] = (cnt != '0) && is_wr;

        // Open, close and count down one bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open[i] <= 1'b0;
                cnt     <= '0;
                is_wr   <= 1'b0;
            end else if (accept && (cmd == CMD_PREA || (cmd == CMD_PRE && sel))) begin
                open[i] <= 1'b0;
                cnt     <= '0;
                is_wr   <= 1'b0;
            end else if (accept && cmd == CMD_ACT && sel) begin
                open[i] <= 1'b1;
            end else if (accept && (cmd == CMD_RD || cmd == CMD_WR) && sel && ap) begin
                cnt   <= CW'(BURST_CYC);
                is_wr <= (cmd == CMD_WR);
            end else if (cnt != '0) begin
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) begin
                    open[i] <= 1'b0;
                    is_wr   <= 1'b0;
                end
            end
        end
    end

    assign wrap_busy = |busy_vec;

endmodule

// File: rtl/ddrmon_rules.sv
// Issue-rule checker.
// Picks one reason code per cycle from the decoded command, the bank
// state and the mode-set gap counter that it keeps itself.
// Assumes bank state is from before the current edge.
module ddrmon_rules
    import ddrmon_pkg::*;
#(
    parameter int NBANK   = 4,
    parameter int MRS_GAP = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  cmd_e                     cmd,
    input  logic                     cke_bad,
    input  logic [$clog2(NBANK)-1:0] bank,
    input  logic [NBANK-1:0]         open,
    input  logic                     wrap_busy,
    output viol_e                    code,
    output logic                     accept
);

    localparam int GW = $clog2(MRS_GAP + 1);

    logic [GW-1:0] gap;

    // Priority selection of the reason code
    always_comb begin
        code = V_NONE;
        if (gap != '0 && cmd != CMD_NOP) begin
            code = V_MRS_GAP;
        end else if (cke_bad) begin
            code = V_CKE_BAD;
        end else begin
            case (cmd)
                CMD_MRS, CMD_EMRS: if (|open) code = V_MRS_OPEN;
                CMD_REF, CMD_SRE:  if (|open) code = V_REF_OPEN;
                CMD_ACT:           if (open[bank]) code = V_ACT_OPEN;
                CMD_RD, CMD_WR: begin
                    if (wrap_busy)       code = V_WRAP_BUSY;
                    else if (!open[bank]) code = V_CLOSED;
                end
                default: code = V_NONE;
            endcase
        end
    end

    assign accept = (code == V_NONE);

    // Quiet-gap counter started by an accepted mode set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap <= '0;
        end else if (accept && (cmd == CMD_MRS || cmd == CMD_EMRS)) begin
            gap <= GW'(MRS_GAP);
        end else if (gap != '0) begin
            gap <= gap - GW'(1);
        end
    end

endmodule

// File: rtl/ddr_cmd_monitor.sv
// DDR SDRAM command bus monitor, top level.
// Decodes the bus, tracks bank and power state, and flags rule breaks.
// Assumes the bus is sampled on the rising edge and that cke_prev_i
// carries CKE from the previous cycle. All outputs are registered.
module ddr_cmd_monitor
    import ddrmon_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int MRS_GAP   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cke_prev_i,
    input  logic       cke_i,
    input  logic       cs_n_i,
    input  logic       ras_n_i,
    input  logic       cas_n_i,
    input  logic       we_n_i,
    input  logic [1:0] ba_i,
    input  logic       a10_i,
    output logic [3:0] cmd_o,
    output logic [1:0] bank_o,
    output logic       auto_pre_o,
    output logic [3:0] bank_open_o,
    output logic [1:0] pwr_o,
    output logic       viol_o,
    output logic [2:0] viol_code_o
);

    localparam int NBANK     = 4;
    localparam int BURST_CYC = BURST_LEN / 2;

    cmd_e  cmd;
    logic  cke_bad;
    pwr_e  pwr_q;
    viol_e code;
    logic  accept;
    logic  wrap_busy;
    logic  is_access;

    assign is_access = (cmd == CMD_RD) || (cmd == CMD_WR);

    ddrmon_decode u_dec (
        .cke_prev (cke_prev_i),
        .cke      (cke_i),
        .cs_n     (cs_n_i),
        .ras_n    (ras_n_i),
        .cas_n    (cas_n_i),
        .we_n     (we_n_i),
        .ba       (ba_i),
        .a10      (a10_i),
        .pwr      (pwr_q),
        .cmd      (cmd),
        .cke_bad  (cke_bad)
    );

    ddrmon_rules #(.NBANK(NBANK), .MRS_GAP(MRS_GAP)) u_rules (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .cke_bad   (cke_bad),
        .bank      (ba_i),
        .open      (bank_open_o),
        .wrap_busy (wrap_busy),
        .code      (code),
        .accept    (accept)
    );

    ddrmon_banks #(.NBANK(NBANK), .BURST_CYC(BURST_CYC)) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .cmd       (cmd),
        .bank      (ba_i),
        .ap        (a10_i),
        .open      (bank_open_o),
        .wrap_busy (wrap_busy)
    );

    // Power state follows accepted entry and exit commands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_q <= PWR_ACTIVE;
        end else if (accept) begin
            case (cmd)
                CMD_SRE:          pwr_q <= PWR_SELF;
                CMD_PDE:          pwr_q <= (|bank_open_o) ? PWR_PD_ACT : PWR_PD_PRE;
                CMD_SRX, CMD_PDX: pwr_q <= PWR_ACTIVE;
                default:          pwr_q <= pwr_q;
            endcase
        end
    end

    // Register the decoded view of this cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_o       <= CMD_NOP;
            bank_o      <= '0;
            auto_pre_o  <= 1'b0;
            viol_o      <= 1'b0;
            viol_code_o <= V_NONE;
        end else begin
            cmd_o       <= cmd;
            bank_o      <= ba_i;
            auto_pre_o  <= is_access && a10_i;
            viol_o      <= !accept;
            viol_code_o <= code;
        end
    end

    assign pwr_o = pwr_q;

endmodule

// File: rtl/ddrmon_checker.sv
// Property checker for the DDR command bus monitor, bound to the top.
// Watches only the top-level outputs over time.
module ddrmon_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] cmd_o,
    input logic [1:0] bank_o,
    input logic       auto_pre_o,
    input logic [3:0] bank_open_o,
    input logic [1:0] pwr_o,
    input logic       viol_o
);

    AST_NOP_OPENS_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 4'd0) |-> ((bank_open_o & ~$past(bank_open_o)) == 4'd0)); // R2

    AST_ACT_OPENS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 4'd6 && !viol_o) |-> bank_open_o[bank_o]); // R3

    AST_AP_ONLY_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        auto_pre_o |-> (cmd_o == 4'd7 || cmd_o == 4'd8)); // R4

    AST_PREA_CLOSES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 4'd11 && !viol_o) |-> (bank_open_o == 4'd0)); // R5

    AST_MRS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(cmd_o) == 4'd1 || $past(cmd_o) == 4'd2) && !$past(viol_o) && cmd_o != 4'd0)
        |-> viol_o); // R6

    AST_SELF_REF_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_o == 2'd1) |-> (bank_open_o == 4'd0)); // R8

endmodule

bind ddr_cmd_monitor ddrmon_checker u_ddrmon_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_o       (cmd_o),
    .bank_o      (bank_o),
    .auto_pre_o  (auto_pre_o),
    .bank_open_o (bank_open_o),
    .pwr_o       (pwr_o),
    .viol_o      (viol_o)
);

// File: tb/tb_ddr_cmd_monitor.sv
// Directed bench for the DDR command bus monitor.
module tb_ddr_cmd_monitor;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cke_prev, cke, cs_n, ras_n, cas_n, we_n, a10;
    logic [1:0] ba;
    logic [3:0] cmd_o;
    logic [1:0] bank_o;
    logic       auto_pre_o;
    logic [3:0] bank_open_o;
    logic [1:0] pwr_o;
    logic       viol_o;
    logic [2:0] viol_code_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ddr_cmd_monitor dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cke_prev_i  (cke_prev),
        .cke_i       (cke),
        .cs_n_i      (cs_n),
        .ras_n_i     (ras_n),
        .cas_n_i     (cas_n),
        .we_n_i      (we_n),
        .ba_i        (ba),
        .a10_i       (a10),
        .cmd_o       (cmd_o),
        .bank_o      (bank_o),
        .auto_pre_o  (auto_pre_o),
        .bank_open_o (bank_open_o),
        .pwr_o       (pwr_o),
        .viol_o      (viol_o),
        .viol_code_o (viol_code_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One bus cycle: drive at the falling edge, sample after the next rise
    task automatic cyc(input logic kp, input logic k, input logic c, input logic r,
                       input logic cs, input logic w, input logic [1:0] b, input logic a);
        cke_prev = kp; cke = k; cs_n = c; ras_n = r; cas_n = cs; we_n = w; ba = b; a10 = a;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic nop();                        cyc(1, 1, 0, 1, 1, 1, 2'd0, 0); endtask
    task automatic act(input logic [1:0] b);     cyc(1, 1, 0, 0, 1, 1, b, 0);    endtask
    task automatic rd(input logic [1:0] b, input logic a); cyc(1, 1, 0, 1, 0, 1, b, a); endtask
    task automatic wr(input logic [1:0] b, input logic a); cyc(1, 1, 0, 1, 0, 0, b, a); endtask
    task automatic pre(input logic [1:0] b);     cyc(1, 1, 0, 0, 1, 0, b, 0);    endtask
    task automatic prea(input logic [1:0] b);    cyc(1, 1, 0, 0, 1, 0, b, 1);    endtask
    task automatic mrs(input logic [1:0] b);     cyc(1, 1, 0, 0, 0, 0, b, 0);    endtask
    task automatic refr();                       cyc(1, 1, 0, 0, 0, 1, 2'd0, 0); endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cke_prev = 1; cke = 1; cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; ba = 0; a10 = 0;
        repeat (3) @(negedge clk);
        chk("R13", "cmd in reset", cmd_o, 0);
        chk("R13", "banks in reset", bank_open_o, 0);
        chk("R13", "pwr in reset", pwr_o, 0);
        chk("R13", "viol in reset", viol_o, 0);
        rst_n = 1'b1;
        nop();
    endtask

    task automatic t_decode();
        prea(0);
        act(2'd2);
        chk("R1", "act code", cmd_o, 6);
        chk("R3", "bank C index", bank_o, 2);
        chk("R3", "open after act C", bank_open_o, 4'b0100);
        act(2'd1);
        chk("R3", "open after act B", bank_open_o, 4'b0110);
        rd(2'd2, 0);
        chk("R1", "read code", cmd_o, 7);
        chk("R4", "read no ap", auto_pre_o, 0);
        wr(2'd1, 0);
        chk("R1", "write code", cmd_o, 8);
        cyc(1, 1, 0, 1, 1, 0, 2'd0, 0);
        chk("R1", "burst stop code", cmd_o, 9);
        pre(2'd1);
        chk("R5", "precharge one code", cmd_o, 10);
        chk("R5", "only bank B closed", bank_open_o, 4'b0100);
        act(2'd3);
        chk("R3", "open after act D", bank_open_o, 4'b1100);
        prea(2'd1);
        chk("R5", "precharge all code", cmd_o, 11);
        chk("R5", "all closed", bank_open_o, 4'b0000);
    endtask

    task automatic t_nop_and_bad();
        prea(0);
        act(2'd0);
        nop();
        chk("R2", "nop code", cmd_o, 0);
        chk("R2", "nop keeps banks", bank_open_o, 4'b0001);
        cyc(1, 1, 1, 0, 0, 0, 2'd3, 1);
        chk("R2", "deselect code", cmd_o, 0);
        chk("R2", "deselect keeps banks", bank_open_o, 4'b0001);
        rd(2'd3, 0);
        chk("R12", "read closed reason", viol_code_o, 5);
        act(2'd0);
        chk("R12", "act open reason", viol_code_o, 4);
        chk("R12", "flagged keeps banks", bank_open_o, 4'b0001);
        cyc(1, 0, 0, 0, 1, 1, 2'd2, 0);
        chk("R12", "cke fall on act reason", viol_code_o, 7);
        chk("R12", "cke fall act no open", bank_open_o, 4'b0001);
        cyc(0, 1, 0, 1, 1, 1, 2'd0, 0);
        chk("R8", "cke rise while active", cmd_o, 0);
    endtask

    task automatic t_read_ap();
        prea(0);
        act(2'd0);
        rd(2'd0, 1);
        chk("R4", "read ap flag", auto_pre_o, 1);
        chk("R10", "open at ap read", bank_open_o, 4'b0001);
        nop();
        chk("R10", "open one cycle later", bank_open_o, 4'b0001);
        nop();
        chk("R10", "closed at burst end", bank_open_o, 4'b0000);
    endtask

    task automatic t_write_ap();
        prea(0);
        act(2'd1);
        act(2'd2);
        wr(2'd1, 1);
        chk("R11", "write ap accepted", viol_o, 0);
        chk("R4", "write ap flag", auto_pre_o, 1);
        rd(2'd2, 0);
        chk("R11", "read in burst reason", viol_code_o, 6);
        wr(2'd2, 0);
        chk("R11", "write in burst reason", viol_code_o, 6);
        chk("R10", "written bank closed", bank_open_o, 4'b0100);
        rd(2'd2, 0);
        chk("R11", "read after burst ok", viol_o, 0);
    endtask

    task automatic t_mode_set();
        prea(0);
        act(2'd2);
        mrs(2'd0);
        chk("R6", "mode set open reason", viol_code_o, 2);
        prea(0);
        mrs(2'd0);
        chk("R1", "mode set code", cmd_o, 1);
        chk("R6", "mode set accepted", viol_o, 0);
        act(2'd0);
        chk("R6", "gap reason", viol_code_o, 1);
        chk("R6", "gap act no open", bank_open_o, 4'b0000);
        nop();
        chk("R6", "nop in gap ok", viol_o, 0);
        act(2'd0);
        chk("R6", "act after gap ok", viol_o, 0);
        prea(0);
        mrs(2'd1);
        chk("R1", "extended mode set code", cmd_o, 2);
        nop();
        nop();
    endtask

    task automatic t_refresh();
        prea(0);
        act(2'd0);
        refr();
        chk("R7", "refresh open reason", viol_code_o, 3);
        prea(0);
        refr();
        chk("R1", "auto refresh code", cmd_o, 3);
        chk("R7", "refresh accepted", viol_o, 0);
    endtask

    task automatic t_self_refresh();
        prea(0);
        act(2'd3);
        cyc(1, 0, 0, 0, 0, 1, 2'd0, 0);
        chk("R7", "self ref open reason", viol_code_o, 3);
        chk("R7", "self ref refused pwr", pwr_o, 0);
        cyc(0, 1, 0, 1, 1, 1, 2'd0, 0);
        prea(0);
        cyc(1, 0, 0, 0, 0, 1, 2'd0, 0);
        chk("R8", "self ref entry code", cmd_o, 4);
        chk("R8", "pwr self", pwr_o, 1);
        cyc(0, 0, 1, 1, 1, 1, 2'd0, 0);
        chk("R8", "held low nop", cmd_o, 0);
        chk("R8", "still self", pwr_o, 1);
        cyc(0, 1, 1, 1, 1, 1, 2'd0, 0);
        chk("R8", "self ref exit code", cmd_o, 5);
        chk("R8", "pwr active", pwr_o, 0);
    endtask

    task automatic t_power_down();
        prea(0);
        act(2'd3);
        cyc(1, 0, 1, 1, 1, 1, 2'd0, 0);
        chk("R9", "pd entry code", cmd_o, 12);
        chk("R9", "active pd", pwr_o, 2);
        cyc(0, 0, 1, 1, 1, 1, 2'd0, 0);
        cyc(0, 1, 1, 1, 1, 1, 2'd0, 0);
        chk("R9", "pd exit code", cmd_o, 13);
        chk("R9", "pwr active after exit", pwr_o, 0);
        chk("R9", "bank kept over pd", bank_open_o, 4'b1000);
        prea(0);
        cyc(1, 0, 0, 1, 1, 1, 2'd0, 0);
        chk("R9", "precharge pd", pwr_o, 3);
        cyc(0, 1, 0, 1, 1, 1, 2'd0, 0);
        chk("R9", "pd exit from precharge pd", pwr_o, 0);
    endtask

    initial begin
        t_reset();
        t_decode();
        t_nop_and_bad();
        t_read_ap();
        t_write_ap();
        t_mode_set();
        t_refresh();
        t_self_refresh();
        t_power_down();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule